// File: doc/BRIEF.md
# Heartbeat Watchdog with Repeating Reset Pulser

This block watches a processor heartbeat line that has already been synchronized to the system clock. Software running correctly toggles that line. If the line holds one level for longer than a selectable timeout, the block does two things. It drops an active-low watchdog flag, and it issues an active-low reset request of a fixed width that goes with the chosen timeout. If the line then stays stuck, the block issues a further reset pulse after each new timeout, for as long as the line does not move.

Time is measured in ticks of a 32.768 kHz time base, which arrives as a one-cycle strobe. A 3-bit select picks one of eight timeout settings, and each setting has its own reset width. The monitor is switched off, with both outputs held high, in three cases: the heartbeat is reported disconnected, the supply is below the power-fail threshold, or the system runs from backup power.

Top module: `wdog_pulser`

## Requirements
- R1: Any level change on `hb_i`, in a cycle where the monitor is enabled, restarts the timeout count from zero. The tick in that same cycle is not counted.
- R2: When the count reaches the timeout T, `rst_req_n_o` and `wdog_n_o` both go low on the same clock edge. This happens on the T-th tick after the last heartbeat edge.
- R3: Each reset pulse keeps `rst_req_n_o` low for exactly W ticks, then releases it.
- R4: The pulse width is W = BASE_W << s, with shift s = 6,0,1,2,3,4,5,7 for select values 0 to 7. The timeout is T = RATIO × W. With the defaults BASE_W=128 and RATIO=6, select 0 gives 49152/8192 ticks (1.5 s/0.25 s) and select 7 gives 98304/16384 ticks (3 s/0.5 s).
- R5: `wdog_n_o` stays low through pulses and through the gaps between them. It goes high on the clock edge that samples the next level change on `hb_i`.
- R6: With `hb_i` stuck, the next pulse begins T ticks after the previous pulse ended.
- R7: A heartbeat edge during a pulse raises `wdog_n_o` at once. The pulse still runs its full W ticks, and the timeout count restarts from zero when the pulse ends.
- R8: While `hb_open_i`, `pwr_fail_i` or `backup_i` is high, both outputs are high one edge later and the count is held at zero. After release, the first pulse comes on the T-th tick counted from the first enabled cycle.
- R9: Cycles without `tick_i` do not advance the count or the pulse, and do not change `rst_req_n_o`.
- R10: After reset both outputs are high. The first pulse comes on the T-th tick counted from the first cycle after reset release.
- R11: A heartbeat edge in the same cycle as the tick that would complete the timeout takes precedence. No pulse starts, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per 32.768 kHz time-base tick |
| hb_i | input | 1 | Synchronized heartbeat level |
| hb_open_i | input | 1 | Heartbeat reported disconnected; disables monitor |
| pwr_fail_i | input | 1 | Supply below power-fail threshold; disables monitor |
| backup_i | input | 1 | Running from backup power; disables monitor |
| tmo_sel_i | input | 3 | Timeout/pulse-width select (R4) |
| wdog_n_o | output | 1 | Watchdog flag, low after a timeout until the next heartbeat edge |
| rst_req_n_o | output | 1 | Active-low reset request pulse |

## Verification
A wrong count or a wrong limit shows up as a reset pulse that starts, or ends, a tick early or late. The bench therefore measures the exact cycle count from the heartbeat edge to the falling edge of the reset request, and the exact width of the low phase, for every select value. A wrong state, such as a missed return to counting or a lost flag, shows within one timeout. In that case the second pulse of a stuck train is missing or shifted, or the flag reads high between pulses. Errors in the disable path and in edge precedence appear one clock after the stimulus, as an output that is low when it should be high.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_PULSE = 1'b1
  } wdg_state_e;

  localparam int unsigned SEL_W  = 3;
  localparam int unsigned N_SEL  = 8;
  localparam int unsigned MAX_SH = 7;

  // Shift applied to the base pulse width for each select code.
  function automatic int unsigned span_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 32'd6;
      3'd7:    return 32'd7;
      default: return {29'd0, sel} - 32'd1;
    endcase
  endfunction

  function automatic int unsigned pulse_ticks(input logic [SEL_W-1:0] sel,
                                              input int unsigned base);
    return base << span_shift(sel);
  endfunction

  function automatic int unsigned timeout_ticks(input logic [SEL_W-1:0] sel,
                                                input int unsigned base,
                                                input int unsigned ratio);
    return ratio * pulse_ticks(sel, base);
  endfunction

endpackage

// File: rtl/wdg_edge.sv
module wdg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_i,
  output logic edge_o
);
  logic hb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hb_q <= 1'b0;
    else        hb_q <= hb_i;
  end

  assign edge_o = hb_i ^ hb_q;

endmodule

// File: rtl/wdg_limits.sv
module wdg_limits
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_W = 128,
  parameter int unsigned RATIO  = 6,
  parameter int unsigned CW     = 17
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CW-1:0]    tmo_o,
  output logic [CW-1:0]    pw_o
);
  logic [CW-1:0] tmo_tab [N_SEL];
  logic [CW-1:0] pw_tab  [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_tab
    localparam int unsigned PW  = pulse_ticks(SEL_W'(g), BASE_W);
    localparam int unsigned TMO = timeout_ticks(SEL_W'(g), BASE_W, RATIO);
    assign pw_tab[g]  = CW'(PW);
    assign tmo_tab[g] = CW'(TMO);
  end

  assign tmo_o = tmo_tab[sel_i];
  assign pw_o  = pw_tab[sel_i];

  // R4: every selected pair has a nonzero width shorter than its timeout
  always_comb begin
    p_limit_pair_r4: assert (pw_o != '0 && tmo_o > pw_o);
  end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int unsigned CW      = 17,
  parameter int unsigned CNT_MAX = 98304
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          edge_i,
  input  logic [CW-1:0] tmo_i,
  input  logic [CW-1:0] pw_i,
  output logic          wdog_n_o,
  output logic          rst_req_n_o
);
  wdg_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;
  logic          wdn_q, wdn_d;
  logic          expire;      // timeout reached this cycle
  logic          pulse_done;  // reset pulse ends this cycle

  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    wdn_d      = wdn_q;
    expire     = 1'b0;
    pulse_done = 1'b0;
    if (!en_i) begin
      st_d  = ST_WATCH;
      cnt_d = '0;
      wdn_d = 1'b1;
    end else begin
      if (edge_i) wdn_d = 1'b1;
      case (st_q)
        ST_WATCH: begin
          if (edge_i) begin
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_inc >= tmo_i) begin
              expire = 1'b1;
              st_d   = ST_PULSE;
              cnt_d  = '0;
              wdn_d  = 1'b0;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
        ST_PULSE: begin
          if (tick_i) begin
            if (cnt_inc >= pw_i) begin
              pulse_done = 1'b1;
              st_d       = ST_WATCH;
              cnt_d      = '0;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
        default: st_d = ST_WATCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_WATCH;
      cnt_q <= '0;
      wdn_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      wdn_q <= wdn_d;
    end
  end

  assign rst_req_n_o = (st_q != ST_PULSE);
  assign wdog_n_o    = wdn_q;

  // R8: a disabled monitor shows both outputs high on the next edge
  p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (rst_req_n_o && wdog_n_o));

  // R2: a reset pulse never starts while the flag is high
  p_pulse_lowers_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_n_o) |-> !wdog_n_o);

  // R5: an enabled heartbeat edge raises the flag
  p_edge_clears_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && edge_i) |=> wdog_n_o);

  // R9: without a tick the reset request holds
  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> $stable(rst_req_n_o));

  // R3: the pulse only ends through completion or disable
  p_release_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n_o) |-> $past(pulse_done || !en_i));

  // R2: a detected expiry always produces a pulse
  p_expire_pulses_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !rst_req_n_o);

  // R4: the counter stays inside the longest programmable span
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(CNT_MAX));

endmodule

// File: rtl/wdog_pulser.sv
module wdog_pulser
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_W = 128,
  parameter int unsigned RATIO  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hb_i,
  input  logic             hb_open_i,
  input  logic             pwr_fail_i,
  input  logic             backup_i,
  input  logic [SEL_W-1:0] tmo_sel_i,
  output logic             wdog_n_o,
  output logic             rst_req_n_o
);
  localparam int unsigned MAX_TMO = RATIO * (BASE_W << MAX_SH);
  localparam int unsigned CW      = $clog2(MAX_TMO + 1);

  logic          monitor_en;
  logic          hb_edge;
  logic [CW-1:0] tmo_lim;
  logic [CW-1:0] pw_lim;

  assign monitor_en = !(hb_open_i || pwr_fail_i || backup_i);

  wdg_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .hb_i   (hb_i),
    .edge_o (hb_edge)
  );

  wdg_limits #(
    .BASE_W (BASE_W),
    .RATIO  (RATIO),
    .CW     (CW)
  ) u_limits (
    .sel_i (tmo_sel_i),
    .tmo_o (tmo_lim),
    .pw_o  (pw_lim)
  );

  wdg_core #(
    .CW      (CW),
    .CNT_MAX (MAX_TMO)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (monitor_en),
    .tick_i      (tick_i),
    .edge_i      (hb_edge),
    .tmo_i       (tmo_lim),
    .pw_i        (pw_lim),
    .wdog_n_o    (wdog_n_o),
    .rst_req_n_o (rst_req_n_o)
  );

  // R10: outputs are high while in reset
  p_reset_high_r10: assert property (@(posedge clk)
    !rst_n |=> (wdog_n_o && rst_req_n_o));

endmodule

// File: tb/wdog_pulser_test.sv
module wdog_pulser_test;
  localparam int unsigned BW = 8;
  localparam int unsigned RT = 6;
  localparam int LIMIT = 20000;

  // {select, expected timeout ticks, expected width ticks}
  localparam int VEC [8][3] = '{
    '{1, 48, 8},   '{3, 192, 32}, '{0, 3072, 512}, '{2, 96, 16},
    '{5, 768, 128}, '{4, 384, 64}, '{7, 6144, 1024}, '{6, 1536, 256}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, tick = 1'b1, hb = 1'b0;
  logic       hb_open = 1'b0, pwr_fail = 1'b0, backup = 1'b0;
  logic [2:0] sel = 3'd1;
  logic       wdog_n, rst_req_n;
  int n_run = 0, n_fail = 0;

  wdog_pulser #(.BASE_W(BW), .RATIO(RT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hb_i(hb),
    .hb_open_i(hb_open), .pwr_fail_i(pwr_fail), .backup_i(backup),
    .tmo_sel_i(sel), .wdog_n_o(wdog_n), .rst_req_n_o(rst_req_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_low(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst_req_n && n < LIMIT);
  endtask

  task automatic wait_high(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_req_n && n < LIMIT);
  endtask

  task automatic disable_by(input int which);
    case (which % 3)
      0:       hb_open = 1'b1;
      1:       pwr_fail = 1'b1;
      default: backup = 1'b1;
    endcase
    @(negedge clk);
    check(wdog_n && rst_req_n, "R8 disable", {wdog_n, rst_req_n}, 3);
    hb_open = 1'b0; pwr_fail = 1'b0; backup = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, m;
    repeat (3) @(negedge clk);
    check(wdog_n && rst_req_n, "R10 reset state", {wdog_n, rst_req_n}, 3);
    rst_n = 1'b1;
    wait_low(n);
    check(n == 48, "R10 first pulse after reset", n, 48);
    wait_high(n);
    check(n == 8, "R3 width after reset", n, 8);

    // Vector walk: timeout, width, repeat, edge inside pulse, disable
    for (int i = 0; i < 8; i++) begin
      int t, w;
      sel = 3'(VEC[i][0]); t = VEC[i][1]; w = VEC[i][2];
      if (i == 0) disable_by(0);
      hb = ~hb;
      wait_low(n);
      check(n == t + 1, "R1 R4 timeout", n, t + 1);
      check(!wdog_n, "R2 flag low at timeout", wdog_n, 0);
      wait_high(n);
      check(n == w, "R3 R4 pulse width", n, w);
      check(!wdog_n, "R5 flag held between pulses", wdog_n, 0);
      wait_low(n);
      check(n == t, "R6 repeat spacing", n, t);
      repeat (2) @(negedge clk);
      hb = ~hb;
      @(negedge clk);
      check(wdog_n && !rst_req_n, "R7 R5 edge in pulse", {wdog_n, rst_req_n}, 2);
      wait_high(m);
      check(m + 1 == w - 2, "R7 pulse completes", m + 1, w - 2);
      wait_low(n);
      check(n == t, "R7 restart at pulse end", n, t);
      disable_by(i + 1);
    end

    // R8: fresh count after release without a heartbeat edge
    sel = 3'd1;
    disable_by(2);
    wait_low(n);
    check(n == 48, "R8 count after release", n, 48);
    disable_by(0);

    // R9: no tick, no progress
    tick = 1'b0; hb = ~hb;
    repeat (200) @(negedge clk);
    check(rst_req_n && wdog_n, "R9 frozen without tick", {wdog_n, rst_req_n}, 3);
    tick = 1'b1;
    wait_low(n);
    check(n == 48, "R9 count resumes", n, 48);
    disable_by(1);

    // R11: edge together with the completing tick wins
    hb = ~hb;
    repeat (48) @(negedge clk);
    check(rst_req_n, "R11 before final tick", rst_req_n, 1);
    hb = ~hb;
    @(negedge clk);
    check(rst_req_n && wdog_n, "R11 edge beats expiry", {wdog_n, rst_req_n}, 3);
    wait_low(n);
    check(n + 1 == 49, "R11 restarted count", n + 1, 49);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule